// File: doc/BRIEF.md
# Dual-Mode Text and Bitmap Pixel Generator

This block turns the contents of a 512-byte screen buffer into a serial one-bit video stream. It reads the same buffer in one of two ways. In bitmap mode each visible line is eight consecutive bytes, each shown as eight pixels two clocks wide, giving 64 pixels across. In text mode each visible line is sixteen character codes, each expanded through an internal 128-glyph font into eight one-clock pixels. The line and row position come from an external timing block. The block produces the buffer address and read strobe, expands the returned bytes, and drives the video bit.

Each text cell is eight scanlines tall. The sixteen codes of a text row are therefore fetched again on every one of its eight scanlines, and the scanline number within the cell selects the glyph row. A configuration input picks bit 7 or bit 6 of each code as a reverse-video flag for that character. A separate input inverts the whole picture. Outside the active window the output is forced low, so the picture inversion never leaks into the margins.

All activity runs on one clock, the text pixel clock. A buffer byte requested in the fetch cycle is expected on the read-data input two cycles later, and its first pixel appears on the video output four cycles after the fetch cycle.

Top module: `txtgfx_pixgen`

## Requirements
- R1: While rst_n is low, and after its release until the first fetch, vid, mem_rd and mem_addr are all zero.
- R2: In bitmap mode (mode_text=0), a cycle with hactive, vactive and hpos[3:0]=0 causes mem_rd=1 in the next cycle with mem_addr = {base, vpos[7:2], hpos[6:4]}.
- R3: In text mode (mode_text=1), a cycle with hactive, vactive and hpos[2:0]=0 causes mem_rd=1 in the next cycle with mem_addr = {base, vpos[7:3], hpos[6:3]}, so the same sixteen bytes are read on each of a text row's eight scanlines.
- R4: In bitmap mode, the video bit for input position hpos is bit 7-hpos[3:1] of the byte fetched for that position, so each byte is shown MSB first with every bit lasting two clocks.
- R5: In text mode, the video bit for hpos is bit 7-hpos[2:0] of the glyph row. For code c = byte[6:0] and line l = vpos[2:0], the glyph row is {c,1} XOR {l,l,l[1:0]}, and l counts from 0 to 7 in natural order.
- R6: The read data is taken from mem_rdata two cycles after the fetch cycle. The pixel for an input cycle appears on vid exactly four clock cycles later.
- R7: With inv_sel=0, bit 7 of a character byte inverts all eight pixels of that character; with inv_sel=1, bit 6 does. The code is always bits [6:0].
- R8: invert=1 complements the video of both modes inside the active window.
- R9: For an input cycle without both hactive and vactive, vid four cycles later is 0 whatever invert is, and no read strobe follows it.
- R10: mem_rd is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Text pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpos | input | 7 | Horizontal position within the active line, in text pixels |
| hactive | input | 1 | Horizontal active window |
| vpos | input | 8 | Scanline index within the active frame |
| vactive | input | 1 | Vertical active window |
| mode_text | input | 1 | 1 selects text mode, 0 selects bitmap mode |
| invert | input | 1 | Whole-picture inversion |
| inv_sel | input | 1 | Reverse-video flag bit: 0 selects bit 7, 1 selects bit 6 |
| base | input | 7 | Upper address bits of the screen buffer |
| mem_rdata | input | 8 | Buffer read data, valid the cycle after mem_rd |
| mem_addr | output | 16 | Buffer read address |
| mem_rd | output | 1 | Buffer read strobe |
| vid | output | 1 | Serial video bit |

## Verification
A wrong fetch counter or address mux shows on mem_addr one cycle after the fetch cycle, and as wrong pixels three cycles after that. A corrupted shift count or pixel-rate flag garbles the video within the same eight- or sixteen-clock byte slot, and it cannot carry past the next load. A stale reverse-video latch or a wrong glyph line shows as a whole character of wrong pixels. A fault in the blanking delay shows on the first or last four cycles around each active window, most plainly when invert is high. The bench compares every output on every cycle, so any such fault is reported in the cycle it first appears.

// File: rtl/pixgen_pkg.sv
package pixgen_pkg;

    localparam int BYTE_W = 8;
    localparam int CODE_W = 7;
    localparam int LINE_W = 3;

    // Computed glyph store: 128 codes x 8 rows, no stored table.
    function automatic logic [BYTE_W-1:0] glyph_row(input logic [CODE_W-1:0] code,
                                                    input logic [LINE_W-1:0] line);
        return {code, 1'b1} ^ {line, line, line[1:0]};
    endfunction

endpackage

// File: rtl/pixgen_fetch.sv
module pixgen_fetch
    import pixgen_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BASE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        hpos,
    input  logic              hactive,
    input  logic [7:0]        vpos,
    input  logic              vactive,
    input  logic              mode_text,
    input  logic              inv_sel,
    input  logic [BASE_W-1:0] base,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              ld_o,
    output logic              ld_text_o,
    output logic [LINE_W-1:0] ld_line_o,
    output logic              ld_isel_o
);
    localparam int LOW_W = ADDR_W - BASE_W;

    typedef struct packed {
        logic              load;
        logic              text;
        logic [LINE_W-1:0] line;
        logic              isel;
    } stg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
        stg_t              s1;
        stg_t              s2;
    } state_t;

    state_t st_d, st_q;
    logic              fire;
    logic [LOW_W-1:0]  low;

    always_comb begin
        st_d = st_q;
        fire = hactive && vactive &&
               (mode_text ? (hpos[2:0] == 3'd0) : (hpos[3:0] == 4'd0));
        low  = mode_text ? LOW_W'({vpos[7:3], hpos[6:3]})
                         : LOW_W'({vpos[7:2], hpos[6:4]});
        st_d.rd = fire;
        if (fire) begin
            st_d.addr = {base, low};
        end
        st_d.s1.load = fire;
        st_d.s1.text = mode_text;
        st_d.s1.line = vpos[2:0];
        st_d.s1.isel = inv_sel;
        st_d.s2      = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = st_q.addr;
    assign mem_rd    = st_q.rd;
    assign ld_o      = st_q.s2.load;
    assign ld_text_o = st_q.s2.text;
    assign ld_line_o = st_q.s2.line;
    assign ld_isel_o = st_q.s2.isel;

    AST_FETCH_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> $past(hactive && vactive)); // R9
    AST_FETCH_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R10
    AST_BASE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> mem_addr[ADDR_W-1:LOW_W] == $past(base)); // R2
    AST_TEXT_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mode_text)) |-> mem_addr[LOW_W-1:LOW_W-5] == $past(vpos[7:3])); // R3

endmodule

// File: rtl/pixgen_font.sv
module pixgen_font
    import pixgen_pkg::*;
(
    input  logic [BYTE_W-1:0] rdata,
    input  logic [LINE_W-1:0] line,
    input  logic              text,
    input  logic              isel,
    output logic [BYTE_W-1:0] pattern
);
    logic rev;

    always_comb begin
        rev = isel ? rdata[6] : rdata[7];
        if (text) begin
            pattern = glyph_row(rdata[CODE_W-1:0], line) ^ {BYTE_W{rev}};
        end else begin
            pattern = rdata;
        end
    end

endmodule

// File: rtl/pixgen_shift.sv
module pixgen_shift
    import pixgen_pkg::*;
#(
    parameter int ACT_DLY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_text,
    input  logic [BYTE_W-1:0] pattern,
    input  logic              act_in,
    input  logic              invert,
    output logic              vid
);
    localparam int CNT_W = 4;

    typedef struct packed {
        logic [BYTE_W-1:0]  sh;
        logic [CNT_W-1:0]   cnt;
        logic               text;
        logic [ACT_DLY-1:0] act;
        logic               vid;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.act = {st_q.act[ACT_DLY-2:0], act_in};
        if (load) begin
            st_d.sh   = pattern;
            st_d.cnt  = '0;
            st_d.text = load_text;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.text || st_q.cnt[0]) begin
                st_d.sh = {st_q.sh[BYTE_W-2:0], 1'b0};
            end
        end
        st_d.vid = st_q.act[ACT_DLY-1] & (st_q.sh[BYTE_W-1] ^ invert);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vid = st_q.vid;

    AST_BITMAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !st_q.text && !st_q.cnt[0]) |=> st_q.sh[BYTE_W-1] == $past(st_q.sh[BYTE_W-1])); // R4

endmodule

// File: rtl/txtgfx_pixgen.sv
module txtgfx_pixgen
    import pixgen_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BASE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        hpos,
    input  logic              hactive,
    input  logic [7:0]        vpos,
    input  logic              vactive,
    input  logic              mode_text,
    input  logic              invert,
    input  logic              inv_sel,
    input  logic [BASE_W-1:0] base,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              vid
);
    localparam int PIX_LAT = 4;

    logic              ld;
    logic              ld_text;
    logic [LINE_W-1:0] ld_line;
    logic              ld_isel;
    logic [BYTE_W-1:0] pattern;

    pixgen_fetch #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .hpos      (hpos),
        .hactive   (hactive),
        .vpos      (vpos),
        .vactive   (vactive),
        .mode_text (mode_text),
        .inv_sel   (inv_sel),
        .base      (base),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .ld_o      (ld),
        .ld_text_o (ld_text),
        .ld_line_o (ld_line),
        .ld_isel_o (ld_isel)
    );

    pixgen_font u_font (
        .rdata   (mem_rdata),
        .line    (ld_line),
        .text    (ld_text),
        .isel    (ld_isel),
        .pattern (pattern)
    );

    pixgen_shift #(.ACT_DLY(PIX_LAT - 1)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .load_text (ld_text),
        .pattern   (pattern),
        .act_in    (hactive && vactive),
        .invert    (invert),
        .vid       (vid)
    );

    AST_BLANK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        vid |-> $past(hactive && vactive, 4)); // R9

endmodule

// File: tb/txtgfx_pixgen_tb_top.sv
module txtgfx_pixgen_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic [6:0]  hpos;
    logic        hactive;
    logic [7:0]  vpos;
    logic        vactive;
    logic        mode_text;
    logic        invert;
    logic        inv_sel;
    logic [6:0]  base;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        vid;

    txtgfx_pixgen dut_i (
        .clk(clk), .rst_n(rst_n), .hpos(hpos), .hactive(hactive), .vpos(vpos),
        .vactive(vactive), .mode_text(mode_text), .invert(invert), .inv_sel(inv_sel),
        .base(base), .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd), .vid(vid)
    );

    logic [7:0] mem [512];

    always_ff @(posedge clk) begin
        if (!rst_n) mem_rdata <= 8'h00;
        else if (mem_rd) mem_rdata <= mem[mem_addr[8:0]];
    end

    typedef struct packed {
        logic       ha;
        logic       va;
        logic [6:0] hp;
        logic [7:0] vp;
        logic       text;
        logic       inv;
        logic       isel;
        logic [6:0] base;
    } in_t;

    in_t         hist [8];
    int unsigned cyc;
    int          n_chk;
    int          n_bad;
    bit          done;
    logic        prev_rd;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic exp_vid(input in_t h);
        logic [7:0] b;
        logic [7:0] row;
        logic       rv;
        if (!(h.ha && h.va)) return 1'b0;
        if (h.text) begin
            b   = mem[{h.vp[7:3], h.hp[6:3]}];
            rv  = h.isel ? b[6] : b[7];
            row = ({b[6:0], 1'b1} ^ {h.vp[2:0], h.vp[2:0], h.vp[1:0]}) ^ {8{rv}};
            return row[7 - h.hp[2:0]] ^ h.inv;
        end
        b = mem[{h.vp[7:2], h.hp[6:4]}];
        return b[7 - h.hp[3:1]] ^ h.inv;
    endfunction

    function automatic logic exp_fire(input in_t h);
        return h.ha && h.va && (h.text ? (h.hp[2:0] == 3'd0) : (h.hp[3:0] == 4'd0));
    endfunction

    function automatic logic [15:0] exp_addr(input in_t h);
        return h.text ? {h.base, h.vp[7:3], h.hp[6:3]} : {h.base, h.vp[7:2], h.hp[6:4]};
    endfunction

    function automatic string pix_tag(input in_t h);
        logic [7:0] b;
        if (!(h.ha && h.va)) return "R9";
        if (h.inv) return "R8";
        if (h.text) begin
            b = mem[{h.vp[7:3], h.hp[6:3]}];
            if (h.isel ? b[6] : b[7]) return "R7";
            if (h.hp[2:0] == 3'd0) return "R6";
            return "R5";
        end
        if (h.hp[3:0] == 4'd0) return "R6";
        return "R4";
    endfunction

    task automatic step(input in_t nxt);
        in_t h1;
        in_t h4;
        @(negedge clk);
        h1 = hist[(cyc - 1) % 8];
        h4 = hist[(cyc - 4) % 8];
        if (rst_n) begin
            if (exp_fire(h1)) begin
                check(h1.text ? "R3" : "R2", int'(mem_rd), 1);
                check(h1.text ? "R3" : "R2", int'(mem_addr), int'(exp_addr(h1)));
            end else begin
                check(h1.ha && h1.va ? (h1.text ? "R3" : "R2") : "R9", int'(mem_rd), 0);
            end
            if (prev_rd) check("R10", int'(mem_rd), 0);
            check(pix_tag(h4), int'(vid), int'(exp_vid(h4)));
        end
        prev_rd = mem_rd;
        hpos      = nxt.hp;
        hactive   = nxt.ha;
        vpos      = nxt.vp;
        vactive   = nxt.va;
        mode_text = nxt.text;
        invert    = nxt.inv;
        inv_sel   = nxt.isel;
        base      = nxt.base;
        hist[cyc % 8] = nxt;
        cyc++;
    endtask

    task automatic run_line(input logic text, input logic inv, input logic isel,
                            input logic [6:0] bs, input logic [7:0] vp, input logic va);
        in_t n;
        n = '0;
        n.text = text; n.inv = inv; n.isel = isel; n.base = bs; n.vp = vp; n.va = va;
        for (int x = 0; x < 128; x++) begin
            n.ha = 1'b1;
            n.hp = 7'(x);
            step(n);
        end
        for (int x = 0; x < 8; x++) begin
            n.ha = 1'b0;
            n.hp = 7'(x);
            step(n);
        end
    endtask

    initial begin
        in_t idle;
        int unsigned seed;
        n_chk = 0; n_bad = 0; done = 1'b0; prev_rd = 1'b0;
        seed = 32'h5EED;
        void'($urandom(seed));
        cyc = 8;
        for (int i = 0; i < 8; i++) hist[i] = '0;
        for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
        idle = '0;
        rst_n = 1'b0;
        hpos = '0; hactive = 1'b0; vpos = '0; vactive = 1'b0;
        mode_text = 1'b0; invert = 1'b0; inv_sel = 1'b0; base = '0;
        idle.ha = 1'b1; idle.va = 1'b1; idle.inv = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            hactive = 1'b1; vactive = 1'b1; invert = 1'b1;
            check("R1", int'(vid), 0);
            check("R1", int'(mem_rd), 0);
            check("R1", int'(mem_addr), 0);
        end
        hactive = 1'b0; vactive = 1'b0; invert = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle = '0;
        for (int i = 0; i < 6; i++) step(idle);

        // Directed: reverse-video flag bits on text row 0
        mem[0] = 8'h80; mem[1] = 8'h40; mem[2] = 8'hC0; mem[3] = 8'h00;
        mem[4] = 8'hFF; mem[5] = 8'h7F; mem[6] = 8'h3F; mem[7] = 8'hBF;
        for (int l = 0; l < 8; l++) run_line(1'b1, 1'b0, 1'b0, 7'h7F, 8'(l), 1'b1);
        for (int l = 0; l < 8; l++) run_line(1'b1, 1'b0, 1'b1, 7'h00, 8'(l), 1'b1);
        // Directed: bitmap with all-ones and alternating bytes, then inverted
        for (int i = 0; i < 8; i++) mem[i] = (i % 2 == 0) ? 8'hFF : 8'hA5;
        run_line(1'b0, 1'b0, 1'b0, 7'h15, 8'd0, 1'b1);
        run_line(1'b0, 1'b1, 1'b0, 7'h15, 8'd3, 1'b1);
        run_line(1'b1, 1'b1, 1'b1, 7'h2A, 8'd255, 1'b1);
        // Directed: vertical blank with invert high
        run_line(1'b1, 1'b1, 1'b0, 7'h01, 8'd40, 1'b0);
        run_line(1'b0, 1'b1, 1'b0, 7'h01, 8'd40, 1'b0);

        // Random lines
        for (int k = 0; k < 60; k++) begin
            mem[$urandom % 512] = 8'($urandom);
            run_line(1'($urandom), 1'($urandom), 1'($urandom), 7'($urandom),
                     8'($urandom), ($urandom % 8) != 0);
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule